// File: doc/BRIEF.md
# Serial Byte Receiver with Two-Entry Buffer

This block receives asynchronous serial frames on a single input line. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. The bit timing comes from an external strobe, `baudTick`, that pulses once per sixteenth of a bit period. The receiver waits for the line to go low and confirms that low level half a bit later. It then samples each data bit at its midpoint and assembles the byte in a shift register. When it samples the stop bit, it writes the byte into a two-entry first-in first-out buffer.

Two status outputs tell the reader how much data is waiting. `oneFull` means at least one byte is held, and `twoFull` means both entries are occupied. Software can therefore service the receiver one byte at a time, or wait for two bytes and read twice. Each pulse on `rdStrobe` removes the oldest byte. That byte is visible on `rdData` whenever `oneFull` is high. A busy output covers the time from start-bit confirmation to the stop sample. Two error outputs report a low stop bit and a frame lost because the buffer was full.

Top module: `rx_dual_buf`

## Requirements
- R1: After reset, `busy`, `oneFull`, `twoFull`, `overrunErr` and `framingErr` are all 0.
- R2: In idle, a low line seen on a `baudTick` begins start detection. The line is sampled again on the 8th following tick. If it is high there, the receiver goes back to idle, `busy` is never raised and nothing is stored.
- R3: `busy` goes to 1 when the start bit is confirmed low at mid-bit. It returns to 0 at the stop-bit sample, when the byte is written into the buffer.
- R4: Data bits are sampled every 16 ticks, starting 16 ticks after the start confirmation. The first sampled bit becomes bit 0 of the byte, and eight bits make one byte.
- R5: The buffer holds 2 bytes. `oneFull` is 1 whenever at least one byte is held, and `twoFull` is 1 exactly when two bytes are held.
- R6: A one-cycle `rdStrobe` pops the oldest byte, so bytes leave in the order they arrived. While the buffer holds at least one byte, `rdData` shows the oldest byte. A strobe while the buffer is empty has no effect.
- R7: If a frame completes while two bytes are held and no read happens in the same cycle, the new byte is discarded and `overrunErr` is set. `overrunErr` is cleared by the next successful read.
- R8: A stop bit sampled low sets `framingErr` and the byte is still stored. Each completed frame updates `framingErr` from its own stop bit.
- R9: Without `baudTick` pulses the receiver does not advance: line activity alone neither starts a frame nor stores data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| serIn | input | 1 | Serial receive line, idle high |
| rdStrobe | input | 1 | One-cycle read pulse that pops the oldest byte |
| rdData | output | 8 | Oldest buffered byte |
| busy | output | 1 | Frame reception in progress |
| oneFull | output | 1 | At least one byte buffered |
| twoFull | output | 1 | Two bytes buffered |
| overrunErr | output | 1 | A frame was lost because the buffer was full |
| framingErr | output | 1 | The last completed frame had a low stop bit |

## Verification
The bench sends all 256 byte values, so a bit-order or sampling-phase error shows up as reversed or shifted data. It fills both entries and then sends a third frame. A design that overwrote an entry or never raised the overrun flag would return the wrong first byte or leave `overrunErr` low. It drives short glitches, a read on an empty buffer, a low stop bit and line activity with the tick stopped. A receiver that latched a glitch, corrupted a pointer, dropped a badly framed byte or ran without ticks would show a stray byte, wrong ordering or a stuck busy flag.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // sample line into shift register
    logic capture;   // frame complete, write byte
    logic stopBad;   // stop bit was sampled low
  } rxStrb_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    rxS,
  output rxStrb_t strb,
  output logic    busy
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  rxState_t         state, stateNxt;
  logic [CNT_W-1:0] tickCnt, tickCntNxt;
  logic [BIT_W-1:0] bitIdx, bitIdxNxt;

  always_comb begin
    stateNxt     = state;
    tickCntNxt   = tickCnt;
    bitIdxNxt    = bitIdx;
    strb.shiftEn = 1'b0;
    strb.capture = 1'b0;
    strb.stopBad = 1'b0;
    if (baudTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxS) begin
            stateNxt   = ST_START;
            tickCntNxt = '0;
          end
        end
        ST_START: begin
          if (tickCnt == HALF_LAST) begin
            tickCntNxt = '0;
            bitIdxNxt  = '0;
            stateNxt   = rxS ? ST_IDLE : ST_DATA;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == FULL_LAST) begin
            tickCntNxt   = '0;
            strb.shiftEn = 1'b1;
            if (bitIdx == LAST_BIT) stateNxt = ST_STOP;
            else bitIdxNxt = bitIdx + 1'b1;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == FULL_LAST) begin
            tickCntNxt   = '0;
            strb.capture = 1'b1;
            strb.stopBad = !rxS;
            stateNxt     = ST_IDLE;
          end else begin
            tickCntNxt = tickCnt + 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= tickCntNxt;
      bitIdx  <= bitIdxNxt;
    end
  end

  assign busy = (state == ST_DATA) || (state == ST_STOP);

  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && baudTick && tickCnt == HALF_LAST && rxS) |=> (state == ST_IDLE && !busy)) // R2
    else $error("false start not rejected");

  AST_BUSY_ENDS_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.capture)) // R3
    else $error("busy fell without capture");

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> ($stable(state) && $stable(tickCnt))) // R9
    else $error("advanced without tick");

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.capture})) // R4
    else $error("shift and capture together");

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              rdStrobe,
  input  rxStrb_t           strb,
  output logic              rxS,
  output logic [DATA_W-1:0] rdData,
  output logic              oneFull,
  output logic              twoFull,
  output logic              overrunErr,
  output logic              framingErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  // input synchronizer, reset to idle-high
  logic [SYNC-1:0] syncQ;
  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else syncQ <= serIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else syncQ <= {syncQ[SYNC-2:0], serIn};
    end
  endgenerate
  assign rxS = syncQ[SYNC-1];

  // shift register, first bit ends at bit 0
  logic [DATA_W-1:0] shReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.shiftEn) shReg <= {rxS, shReg[DATA_W-1:1]};
  end

  // receive buffer
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              pop, push;

  assign pop  = rdStrobe && (fill != '0);
  assign push = strb.capture && ((fill != CNT_FULL) || pop);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= shReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      unique case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      if (strb.capture && !push) overrunErr <= 1'b1;
      else if (pop)              overrunErr <= 1'b0;
      if (strb.capture)          framingErr <= strb.stopBad;
    end
  end

  assign rdData  = mem[rdPtr];
  assign oneFull = (fill != '0);
  assign twoFull = (fill == CNT_FULL);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_FULL) // R5
    else $error("buffer fill exceeds depth");

  AST_FULL_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && twoFull && !rdStrobe) |=> (overrunErr && twoFull)) // R7
    else $error("overrun not flagged");

  AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && oneFull && !strb.capture) |=> (fill == $past(fill) - 1'b1)) // R6
    else $error("pop did not drain one entry");

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !oneFull && !strb.capture) |=> (!oneFull && $stable(rdPtr))) // R6
    else $error("read on empty changed state");

  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (framingErr == $past(strb.stopBad))) // R8
    else $error("framing flag mismatch");

endmodule

// File: rtl/rx_dual_buf.sv
module rx_dual_buf
  import rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              serIn,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              oneFull,
  output logic              twoFull,
  output logic              overrunErr,
  output logic              framingErr
);

  rxStrb_t strb;
  logic    rxS;

  rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .rxS      (rxS),
    .strb     (strb),
    .busy     (busy)
  );

  rx_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC(SYNC)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .serIn      (serIn),
    .rdStrobe   (rdStrobe),
    .strb       (strb),
    .rxS        (rxS),
    .rdData     (rdData),
    .oneFull    (oneFull),
    .twoFull    (twoFull),
    .overrunErr (overrunErr),
    .framingErr (framingErr)
  );

  AST_BUSY_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !oneFull)) // R1
    else $error("state not clear after reset");

endmodule

// File: tb/rx_dual_buf_tb.sv
module rx_dual_buf_tb_top;

  localparam int TDIV   = 2;
  localparam int BITCYC = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       serIn = 1'b1;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       busy, oneFull, twoFull, overrunErr, framingErr;

  int  total = 0;
  int  bad = 0;
  bit  tickEn = 1'b1;
  int  divCnt = 0;
  bit  midBusy;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  rx_dual_buf dut_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .serIn(serIn),
    .rdStrobe(rdStrobe), .rdData(rdData), .busy(busy), .oneFull(oneFull),
    .twoFull(twoFull), .overrunErr(overrunErr), .framingErr(framingErr)
  );

  always @(negedge clk) begin
    baudTick <= tickEn && (divCnt == 0);
    divCnt   <= (divCnt == TDIV - 1) ? 0 : divCnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic stopVal);
    @(negedge clk);
    serIn = 1'b0;
    repeat (BITCYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serIn = d[i];
      repeat (BITCYC / 2) @(negedge clk);
      if (i == 4) midBusy = busy;
      repeat (BITCYC - BITCYC / 2) @(negedge clk);
    end
    serIn = stopVal;
    repeat (BITCYC) @(negedge clk);
    serIn = 1'b1;
    repeat (BITCYC + 4) @(negedge clk);
  endtask

  task automatic readByte(output logic [7:0] d);
    @(negedge clk);
    d = rdData;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 oneFull", oneFull, 0);
    chk("R1 twoFull", twoFull, 0);
    chk("R1 errs", {overrunErr, framingErr}, 0);

    // R4 R5 R6 sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      sendFrame(8'(v), 1'b1);
      if (v == 0) chk("R3 busy mid-frame", midBusy, 1);
      chk("R3 busy after stop", busy, 0);
      chk("R5 oneFull single", {oneFull, twoFull}, 2'b10);
      readByte(got);
      chk("R4 data", got, v);
      chk("R6 drained", oneFull, 0);
    end

    // R2 glitch shorter than half a bit
    @(negedge clk);
    serIn = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    serIn = 1'b1;
    repeat (BITCYC / 2) @(negedge clk);
    chk("R2 glitch no busy", busy, 0);
    repeat (12 * BITCYC) @(negedge clk);
    chk("R2 glitch nothing stored", oneFull, 0);

    // R5 R7 fill, overrun, order
    sendFrame(8'hA5, 1'b1);
    sendFrame(8'h3C, 1'b1);
    chk("R5 two held", {oneFull, twoFull}, 2'b11);
    chk("R7 no overrun yet", overrunErr, 0);
    sendFrame(8'hE7, 1'b1);
    chk("R7 overrun set", overrunErr, 1);
    chk("R7 still two", twoFull, 1);
    readByte(got);
    chk("R6 oldest first", got, 8'hA5);
    chk("R7 overrun cleared", overrunErr, 0);
    chk("R5 back to one", {oneFull, twoFull}, 2'b10);
    readByte(got);
    chk("R7 dropped byte not kept", got, 8'h3C);
    chk("R5 empty", oneFull, 0);

    // R6 read on empty ignored
    readByte(got);
    chk("R6 empty read flags", {oneFull, twoFull}, 0);
    sendFrame(8'h81, 1'b1);
    readByte(got);
    chk("R6 order after empty read", got, 8'h81);

    // R8 low stop bit
    sendFrame(8'h5A, 1'b0);
    repeat (BITCYC) @(negedge clk);
    chk("R8 framing set", framingErr, 1);
    chk("R8 byte kept", oneFull, 1);
    readByte(got);
    chk("R8 data", got, 8'h5A);
    chk("R8 no extra byte", oneFull, 0);
    sendFrame(8'h0F, 1'b1);
    chk("R8 framing cleared", framingErr, 0);
    readByte(got);
    chk("R8 next data", got, 8'h0F);

    // R9 no ticks: line activity ignored
    tickEn = 1'b0;
    @(negedge clk);
    serIn = 1'b0;
    repeat (20 * BITCYC) @(negedge clk);
    chk("R9 no busy", busy, 0);
    serIn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 nothing stored", oneFull, 0);
    tickEn = 1'b1;
    repeat (BITCYC) @(negedge clk);
    sendFrame(8'hC3, 1'b1);
    readByte(got);
    chk("R9 resumes", got, 8'hC3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule